// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block watches a running calendar, supplied as BCD seconds, minutes, hours with an afternoon indicator, day of month and day of week. It compares that calendar against a 32-bit alarm word held in its own register. Each of the four fields in the alarm word has a private ignore bit, so an alarm can fire every minute, every day, or on one exact weekday and time. A select bit decides whether the day field is matched against the day of month or the day of week.

On a match it latches a sticky alarm flag. The flag drives an interrupt line when interrupts are enabled. A rewrite of the alarm word is accepted only after software has disabled the alarm and a write-allowed status has come back up a fixed number of cycles later.

Software reaches the block through a small write port with a two-bit register select:

- 0 selects the alarm word.
- 1 selects the control register: bit 0 enables the alarm, bit 1 enables the interrupt.
- 2 selects the flag register.
- 3 selects the clear register.

The calendar counter that produces the time inputs and the one-second tick is outside this block.

Top module: `alarm_match_unit`

## Requirements
- R1: The seconds value in alarm bits 6:0 must equal `cur_sec` for a match unless alarm bit 7 is 1, in which case seconds are ignored.
- R2: The minutes value in alarm bits 14:8 must equal `cur_min` for a match unless alarm bit 15 is 1.
- R3: Alarm bits 21:16 must equal `cur_hour` and alarm bit 22 must equal `cur_pm` for a match, unless alarm bit 23 is 1.
- R4: With alarm bit 30 at 0, alarm bits 29:24 are compared against `cur_date`. With bit 30 at 1, alarm bits 27:24 are compared against `cur_wday`. Alarm bit 31 at 1 removes the day field from the match.
- R5: A match is taken only in a cycle where `tick` is high and control bit 0 is set. `alarm_flag` is high from the cycle after that tick.
- R6: Once set, `alarm_flag` stays high through further ticks until a clear command.
- R7: With `CLR_W1C`=0, writing 0 to flag register bit 0 clears the flag, and writes to the clear register have no effect. With `CLR_W1C`=1, writing 1 to clear register bit 0 clears the flag, and writes to the flag register have no effect.
- R8: A clear command in the same cycle as a match leaves `alarm_flag` low.
- R9: `irq` is high exactly when `alarm_flag` is high and control bit 1 is set.
- R10: `wr_allowed` is 1 after reset. It falls one cycle after the alarm enable is set. It rises `SYNC_CYCLES` cycles after the alarm enable is cleared (2 by default).
- R11: A write to the alarm word while `wr_allowed` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per calendar second |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 6 | Current hours, BCD |
| cur_pm | input | 1 | Current afternoon indicator |
| cur_date | input | 6 | Current day of month, BCD |
| cur_wday | input | 3 | Current day of week, 1 to 7 |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 alarm, 1 control, 2 flag, 3 clear |
| wr_data | input | 32 | Write data |
| alarm_flag | output | 1 | Sticky alarm flag |
| wr_allowed | output | 1 | Alarm word may be rewritten |
| irq | output | 1 | Alarm interrupt |

## Verification
A bad field comparison or a wrong ignore bit shows as `alarm_flag` being set, or not set, in the cycle after the tick that tests that field. Each field is therefore driven through a matching and a mismatching value. A stuck handshake counter shows within `SYNC_CYCLES` cycles as `wr_allowed` out of step. A write to the alarm word that was wrongly let through shows at the next tick as a spurious flag. Clear-path faults appear one cycle after the clear write, and the two clear styles are compared against each other on the same stimulus.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
    localparam int ALM_W = 32;
    localparam int FLD_N = 4;
    localparam int FLD_W = 8;

    typedef enum logic [1:0] {
        SEL_ALARM = 2'd0,
        SEL_CTRL  = 2'd1,
        SEL_FLAG  = 2'd2,
        SEL_CLR   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [ALM_W-1:0] alarm;
        logic             alm_en;
        logic             irq_en;
        logic             flag;
    } alm_state_t;
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur_val,
    input  logic [W-1:0] ref_val,
    input  logic         ignore,
    output logic         hit
);
    always_comb begin
        hit = ignore | (cur_val == ref_val);
    end
endmodule

// File: rtl/alarm_wr_gate.sv
module alarm_wr_gate #(
    parameter int SYNC_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic alarm_en,
    output logic wr_ok
);
    localparam int CW = $clog2(SYNC_CYCLES + 2);
    localparam logic [CW-1:0] LAST = CW'(SYNC_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ok;
    } gate_t;

    gate_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (alarm_en) begin
            g_d.cnt = '0;
            g_d.ok  = 1'b0;
        end else if (g_q.cnt != LAST) begin
            g_d.cnt = g_q.cnt + 1'b1;
            g_d.ok  = (g_d.cnt == LAST);
        end else begin
            g_d.ok = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_q.cnt <= LAST;
            g_q.ok  <= 1'b1;
        end else begin
            g_q <= g_d;
        end
    end

    assign wr_ok = g_q.ok;
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
    import alarm_pkg::*;
#(
    parameter int SYNC_CYCLES = 2,
    parameter int CLR_W1C     = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [6:0]       cur_sec,
    input  logic [6:0]       cur_min,
    input  logic [5:0]       cur_hour,
    input  logic             cur_pm,
    input  logic [5:0]       cur_date,
    input  logic [2:0]       cur_wday,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [ALM_W-1:0] wr_data,
    output logic             alarm_flag,
    output logic             wr_allowed,
    output logic             irq
);
    alm_state_t st_d, st_q;

    logic [ALM_W-1:0] alarm_q;
    logic             alarm_en_q;
    logic             clr_hit;
    logic             match_hit;
    logic             wr_ok;

    logic [FLD_W-1:0] cur_fld [FLD_N];
    logic [FLD_W-1:0] ref_fld [FLD_N];
    logic [FLD_N-1:0] ign_fld;
    logic [FLD_N-1:0] fld_hit;

    assign alarm_q    = st_q.alarm;
    assign alarm_en_q = st_q.alm_en;

    // Field layout: seconds, minutes, hours+pm, day (date or weekday)
    always_comb begin
        cur_fld[0] = {1'b0, cur_sec};
        ref_fld[0] = {1'b0, alarm_q[6:0]};
        ign_fld[0] = alarm_q[7];
        cur_fld[1] = {1'b0, cur_min};
        ref_fld[1] = {1'b0, alarm_q[14:8]};
        ign_fld[1] = alarm_q[15];
        cur_fld[2] = {1'b0, cur_pm, cur_hour};
        ref_fld[2] = {1'b0, alarm_q[22], alarm_q[21:16]};
        ign_fld[2] = alarm_q[23];
        if (alarm_q[30]) begin
            cur_fld[3] = {5'b0, cur_wday};
            ref_fld[3] = {4'b0, alarm_q[27:24]};
        end else begin
            cur_fld[3] = {2'b0, cur_date};
            ref_fld[3] = {2'b0, alarm_q[29:24]};
        end
        ign_fld[3] = alarm_q[31];
    end

    for (genvar i = 0; i < FLD_N; i++) begin : g_fld
        alarm_field_cmp #(.W(FLD_W)) u_cmp (
            .cur_val (cur_fld[i]),
            .ref_val (ref_fld[i]),
            .ignore  (ign_fld[i]),
            .hit     (fld_hit[i])
        );
    end

    alarm_wr_gate #(.SYNC_CYCLES(SYNC_CYCLES)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .alarm_en (st_q.alm_en),
        .wr_ok    (wr_ok)
    );

    always_comb begin
        st_d    = st_q;
        clr_hit = 1'b0;
        if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                SEL_ALARM: if (wr_ok) st_d.alarm = wr_data;
                SEL_CTRL: begin
                    st_d.alm_en = wr_data[0];
                    st_d.irq_en = wr_data[1];
                end
                SEL_FLAG: clr_hit = (CLR_W1C == 0) && !wr_data[0];
                SEL_CLR:  clr_hit = (CLR_W1C != 0) && wr_data[0];
                default: ;
            endcase
        end
        match_hit = tick && st_q.alm_en && (&fld_hit);
        if (clr_hit)        st_d.flag = 1'b0;
        else if (match_hit) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alarm_flag = st_q.flag;
    assign wr_allowed = wr_ok;
    assign irq        = st_q.flag & st_q.irq_en;
endmodule

// File: rtl/alarm_match_chk.sv
module alarm_match_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        alarm_en_q,
    input logic        clr_hit,
    input logic        alarm_flag,
    input logic        wr_allowed,
    input logic        irq,
    input logic [31:0] alarm_q
);
    AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> ($past(tick) && $past(alarm_en_q))); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && !clr_hit) |=> alarm_flag); // R6
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit |=> !alarm_flag); // R8
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> alarm_flag); // R9
    AST_WR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_en_q |=> !wr_allowed); // R10
    AST_ALARM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_allowed |=> $stable(alarm_q)); // R11
endmodule

bind alarm_match_unit alarm_match_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .alarm_en_q (alarm_en_q),
    .clr_hit    (clr_hit),
    .alarm_flag (alarm_flag),
    .wr_allowed (wr_allowed),
    .irq        (irq),
    .alarm_q    (alarm_q)
);

// File: tb/alarm_match_unit_tb.sv
`timescale 1ns/1ps
module alarm_match_unit_tb;
    localparam real CLK_P = 20.0;
    localparam logic [1:0] S_ALM = 2'd0, S_CTL = 2'd1, S_FLG = 2'd2, S_CLR = 2'd3;
    localparam logic [31:0] M_SEC = 32'h0000_0080, M_MIN = 32'h0000_8000;
    localparam logic [31:0] M_HR = 32'h0080_0000, M_DAY = 32'h8000_0000;
    localparam logic [31:0] WDSEL = 32'h4000_0000;

    logic clk = 0, rst_n = 0, tick = 0, wr_en = 0, cur_pm = 0;
    logic [6:0] cur_sec = 7'h30, cur_min = 7'h15;
    logic [5:0] cur_hour = 6'h09, cur_date = 6'h12;
    logic [2:0] cur_wday = 3'd3;
    logic [1:0] wr_sel = 0;
    logic [31:0] wr_data = 0;
    logic flag0, ok0, irq0, flag1, ok1, irq1;
    int n_chk = 0, n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    alarm_match_unit #(.SYNC_CYCLES(2), .CLR_W1C(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cur_sec(cur_sec), .cur_min(cur_min),
        .cur_hour(cur_hour), .cur_pm(cur_pm), .cur_date(cur_date), .cur_wday(cur_wday),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .alarm_flag(flag0), .wr_allowed(ok0), .irq(irq0));

    alarm_match_unit #(.SYNC_CYCLES(2), .CLR_W1C(1)) u_dut_w1c (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cur_sec(cur_sec), .cur_min(cur_min),
        .cur_hour(cur_hour), .cur_pm(cur_pm), .cur_date(cur_date), .cur_wday(cur_wday),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .alarm_flag(flag1), .wr_allowed(ok1), .irq(irq1));

    task automatic chk(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic chk2(string req, logic exp);
        chk({req, " dut0 flag"}, flag0, exp);
        chk({req, " dut1 flag"}, flag1, exp);
    endtask

    task automatic bus_wr(logic [1:0] sel, logic [31:0] d);
        @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1;
        @(negedge clk); tick = 0;
    endtask

    task automatic clear_both();
        bus_wr(S_FLG, 32'h0);
        bus_wr(S_CLR, 32'h1);
    endtask

    task automatic load_alarm(logic [31:0] d);
        bus_wr(S_CTL, 32'h0);
        repeat (3) @(negedge clk);
        bus_wr(S_ALM, d);
        bus_wr(S_CTL, 32'h1);
    endtask

    task automatic t_reset();
        chk2("R5 reset", 1'b0);
        chk("R9 reset irq", irq0, 1'b0);
        chk("R10 reset wr_allowed", ok0, 1'b1);
    endtask

    task automatic t_seconds();
        bus_wr(S_ALM, 32'h30 | M_MIN | M_HR | M_DAY);
        bus_wr(S_CTL, 32'h1);
        chk("R10 still allowed one cycle", ok0, 1'b1);
        @(negedge clk);
        chk("R10 dropped after enable", ok0, 1'b0);
        repeat (2) @(negedge clk);
        chk2("R5 no match without tick", 1'b0);
        pulse_tick();
        chk2("R1 seconds match", 1'b1);
    endtask

    task automatic t_clear_style();
        bus_wr(S_FLG, 32'h0);
        chk("R7 flag write clears style0", flag0, 1'b0);
        chk("R7 flag write ignored style1", flag1, 1'b1);
        bus_wr(S_CLR, 32'h1);
        chk("R7 clear reg clears style1", flag1, 1'b0);
        chk("R7 style0 stays clear", flag0, 1'b0);
    endtask

    task automatic t_blocked();
        cur_sec = 7'h31;
        bus_wr(S_ALM, 32'h8080_8080);
        pulse_tick();
        chk2("R11 blocked write / R1 mismatch", 1'b0);
    endtask

    task automatic t_handshake();
        bus_wr(S_CTL, 32'h0);
        chk("R10 low at disable+0", ok0, 1'b0);
        @(negedge clk);
        chk("R10 low at disable+1", ok0, 1'b0);
        @(negedge clk);
        chk("R10 high at disable+2", ok0, 1'b1);
        chk("R10 style1 high", ok1, 1'b1);
        cur_sec = 7'h30;
        pulse_tick();
        chk2("R5 disabled no match", 1'b0);
    endtask

    task automatic t_minutes();
        load_alarm(M_SEC | (32'h15 << 8) | M_HR | M_DAY);
        cur_min = 7'h16; pulse_tick();
        chk2("R2 minutes mismatch", 1'b0);
        cur_min = 7'h15; pulse_tick();
        chk2("R2 minutes match", 1'b1);
        clear_both();
        chk2("R7 both cleared", 1'b0);
    endtask

    task automatic t_hours();
        load_alarm(M_SEC | M_MIN | (32'h09 << 16) | (32'h1 << 22) | M_DAY);
        cur_pm = 0; pulse_tick();
        chk2("R3 pm mismatch", 1'b0);
        cur_pm = 1; pulse_tick();
        chk2("R3 hour+pm match", 1'b1);
        clear_both();
    endtask

    task automatic t_day();
        load_alarm(M_SEC | M_MIN | M_HR | (32'h12 << 24));
        cur_date = 6'h12; pulse_tick();
        chk2("R4 date match", 1'b1);
        clear_both();
        load_alarm(M_SEC | M_MIN | M_HR | WDSEL | (32'h3 << 24));
        cur_date = 6'h05; cur_wday = 3'd3; pulse_tick();
        chk2("R4 weekday match", 1'b1);
        clear_both();
        cur_wday = 3'd4; pulse_tick();
        chk2("R4 weekday mismatch", 1'b0);
    endtask

    task automatic t_sticky_irq();
        cur_wday = 3'd3; pulse_tick();
        chk2("R5 match with irq off", 1'b1);
        chk("R9 irq off when disabled", irq0, 1'b0);
        bus_wr(S_CTL, 32'h3);
        chk("R9 irq on", irq0, 1'b1);
        pulse_tick();
        chk2("R6 sticky across ticks", 1'b1);
        bus_wr(S_FLG, 32'h0);
        chk("R9 irq follows cleared flag", irq0, 1'b0);
        chk("R9 irq stays with flag style1", irq1, 1'b1);
        bus_wr(S_CLR, 32'h1);
        chk("R9 irq low style1", irq1, 1'b0);
        @(negedge clk); tick = 1; wr_en = 1; wr_sel = S_FLG; wr_data = 0;
        @(negedge clk); tick = 0; wr_en = 0;
        chk("R8 clear beats match style0", flag0, 1'b0);
        chk("R8 match sets style1", flag1, 1'b1);
        @(negedge clk); tick = 1; wr_en = 1; wr_sel = S_CLR; wr_data = 1;
        @(negedge clk); tick = 0; wr_en = 0;
        chk("R8 clear beats match style1", flag1, 1'b0);
        chk("R8 match sets style0", flag0, 1'b1);
        clear_both();
    endtask

    initial begin
        #(CLK_P * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_seconds();
        t_clear_style();
        t_blocked();
        t_handshake();
        t_minutes();
        t_hours();
        t_day();
        t_sticky_irq();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule